// File: doc/BRIEF.md
# Scan-Synchronised Input Pulse Stretcher

This block sits between a fast field input and the input-read step of a scan sequencer. A brief pulse on the field input can fall entirely between two read steps. Left alone, the scan would never see it. The block catches the pulse's rising edge and raises a held level. It keeps that level up until a read step has seen it, and then drops it at the next end-of-scan boundary. The length of the stretch therefore follows the scan itself, not a fixed timer.

Pulses are only guaranteed to get through if they arrive no more often than once per two scans. Sometimes a fresh rising edge appears while the held level is still waiting to be consumed. That edge cannot be represented, so the block raises a sticky flag that stays set until it is cleared explicitly. The field input is first brought into the clock domain through a synchroniser whose depth is a parameter (two flops by default).

Top module: `scan_pulse_stretch`

## Requirements
- R1: After reset, heldOut and lostFlag are both 0.
- R2: A rising edge on rawIn asserts heldOut on the third rising clock edge after rawIn goes high (two synchroniser flops, then the held register). A high level that covers only one sampling edge is enough.
- R3: Once heldOut is high, it stays high whatever rawIn does, until a release per R4.
- R4: While heldOut is high, the release condition is a cycle with scanEnd=1, provided that readPhase=1 was seen in that cycle or in an earlier cycle since heldOut rose. heldOut is then 0 after that clock edge. A scanEnd with no read since capture is ignored.
- R5: readPhase and scanEnd high in the same cycle count as a read followed by an end, so they release the held level.
- R6: A rising edge that arrives while heldOut is high, in a cycle that is not a release, sets lostFlag. heldOut stays high and its release timing is not restarted.
- R7: A rising edge in the very cycle of a release is captured anew. heldOut stays high, the read history is cleared, and lostFlag is not set.
- R8: lostFlag stays set until a cycle with lostClr=1. If a new loss happens in the same cycle as lostClr, the flag stays set.
- R9: rawIn held high continuously produces only one capture. After the release, heldOut stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | 1 | Asynchronous field input |
| readPhase | input | 1 | One-cycle strobe: the scan is reading inputs |
| scanEnd | input | 1 | One-cycle strobe: end of the current scan |
| lostClr | input | 1 | Clears the lost-pulse flag |
| heldOut | output | 1 | Stretched input level presented to the scan |
| lostFlag | output | 1 | Sticky flag: a pulse arrived before the previous one was consumed |

## Verification
Two events can land in the same cycle. The first is a release and a fresh capture: the end-of-scan strobe that frees the held level meets a new synchronised rising edge. The bench provokes this by timing a raw pulse so that its edge reaches the detector in exactly the cycle it drives scanEnd. It then judges that heldOut stays high and that lostFlag stays low. The second is a read strobe together with an end strobe. This is covered by a sweep over every read position against every end position after a capture, where a release is expected exactly when the read does not come after the end. Loss-versus-clear in one cycle is judged the same way, by sampling the flag after that edge.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEEN = 2'd2
  } holdState_t;

  typedef struct packed {
    logic grab;
    logic drop;
    logic lostSet;
    logic lostClr;
  } stretchCmd_t;

endpackage

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rawIn,
  input  stretchCmd_t cmd,
  output logic        riseSeen,
  output logic        heldOut,
  output logic        lostFlag
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          heldQ;
  logic          lostQ;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= rawIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], rawIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  assign riseSeen = syncQ[LAST] & ~prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         heldQ <= 1'b0;
    else if (cmd.grab) heldQ <= 1'b1;
    else if (cmd.drop) heldQ <= 1'b0;
  end

  // a loss that happens in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lostQ <= 1'b0;
    else if (cmd.lostSet) lostQ <= 1'b1;
    else if (cmd.lostClr) lostQ <= 1'b0;
  end

  assign heldOut  = heldQ;
  assign lostFlag = lostQ;

  // R2: a detected edge with nothing held must raise the level
  a_r2_edge_grabs: assert property (@(posedge clk) disable iff (!rstN)
    riseSeen && !heldQ |=> heldQ);

  // R9: after an edge, the detector stays quiet for one cycle
  a_r9_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    riseSeen |=> !riseSeen);

endmodule

// File: rtl/sps_control.sv
module sps_control
  import sps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        riseSeen,
  input  logic        readPhase,
  input  logic        scanEnd,
  input  logic        lostClr,
  output stretchCmd_t cmd
);

  holdState_t stateQ;
  holdState_t stateD;
  logic       holding;
  logic       releaseNow;

  assign holding    = (stateQ != ST_IDLE);
  assign releaseNow = scanEnd &&
                      ((stateQ == ST_SEEN) || (stateQ == ST_WAIT && readPhase));

  always_comb begin
    cmd.grab    = riseSeen && (!holding || releaseNow);
    cmd.drop    = releaseNow;
    cmd.lostSet = riseSeen && holding && !releaseNow;
    cmd.lostClr = lostClr;
  end

  always_comb begin
    stateD = stateQ;
    if (cmd.grab)                              stateD = ST_WAIT;
    else if (releaseNow)                       stateD = ST_IDLE;
    else if (stateQ == ST_WAIT && readPhase)   stateD = ST_SEEN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R4: no release while no read has happened since capture
  a_r4_wait_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) && !readPhase |=> (stateQ != ST_IDLE));

  // R5: read and end together release when no new edge arrives
  a_r5_joint_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) && readPhase && scanEnd && !riseSeen |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/scan_pulse_stretch.sv
module scan_pulse_stretch
  import sps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic readPhase,
  input  logic scanEnd,
  input  logic lostClr,
  output logic heldOut,
  output logic lostFlag
);

  stretchCmd_t cmd;
  logic        riseSeen;

  sps_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .rawIn    (rawIn),
    .cmd      (cmd),
    .riseSeen (riseSeen),
    .heldOut  (heldOut),
    .lostFlag (lostFlag)
  );

  sps_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .riseSeen  (riseSeen),
    .readPhase (readPhase),
    .scanEnd   (scanEnd),
    .lostClr   (lostClr),
    .cmd       (cmd)
  );

  // R3: only an end-of-scan strobe can drop the held level
  a_r3_hold_until_end: assert property (@(posedge clk) disable iff (!rstN)
    heldOut && !scanEnd |=> heldOut);

  // R4: every fall of the held level follows an end strobe
  a_r4_fall_on_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(heldOut) |-> $past(scanEnd));

  // R6: a loss never disturbs the held level
  a_r6_lost_keeps_held: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lostFlag) |-> heldOut && $past(heldOut));

  // R8: the flag only drops after a clear request
  a_r8_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lostFlag && !lostClr |=> lostFlag);

endmodule

// File: tb/scan_pulse_stretch_test.sv
`timescale 1ns/1ps
module scan_pulse_stretch_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawIn = 1'b0;
  logic readPhase = 1'b0;
  logic scanEnd = 1'b0;
  logic lostClr = 1'b0;
  logic heldOut;
  logic lostFlag;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scan_pulse_stretch uut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .readPhase(readPhase),
    .scanEnd(scanEnd), .lostClr(lostClr), .heldOut(heldOut), .lostFlag(lostFlag)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic actual, logic expected, string what);
    testCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, actual, expected);
    end
  endtask

  // one-cycle raw pulse, held expected after the third edge
  task automatic pulseAndGrab(string req);
    rawIn = 1'b1;
    step();
    rawIn = 1'b0;
    step();
    check(req, heldOut, 1'b0, "held before sync delay");
    step();
    check(req, heldOut, 1'b1, "held after three edges");
  endtask

  task automatic readAndEnd();
    readPhase = 1'b1;
    scanEnd = 1'b1;
    step();
    readPhase = 1'b0;
    scanEnd = 1'b0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", heldOut, 1'b0, "held in reset");
    check("R1", lostFlag, 1'b0, "lost in reset");
    rstN = 1'b1;
    step();
    check("R1", heldOut, 1'b0, "held after reset");
    check("R1", lostFlag, 1'b0, "lost after reset");

    // R2, R4, R5: sweep read position r against end position e
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < 5; e++) begin
        pulseAndGrab("R2");
        for (int i = 0; i <= e; i++) begin
          readPhase = (i == r);
          scanEnd = (i == e);
          step();
          readPhase = 1'b0;
          scanEnd = 1'b0;
          if (i < e) check("R3", heldOut, 1'b1, "held between strobes");
        end
        check((r == e) ? "R5" : "R4", heldOut, (r <= e) ? 1'b0 : 1'b1,
              "level after end strobe");
        if (r > e) begin
          readAndEnd();
          check("R5", heldOut, 1'b0, "joint strobe release");
        end
        check("R6", lostFlag, 1'b0, "no loss in sweep");
        step();
      end
    end

    // R3: longer raw pulse dropping during hold
    rawIn = 1'b1;
    step(); step(); step();
    rawIn = 1'b0;
    check("R3", heldOut, 1'b1, "held while raw high");
    step(); step(); step();
    check("R3", heldOut, 1'b1, "held after raw low");
    readAndEnd();
    check("R4", heldOut, 1'b0, "release after read");

    // R6: second pulse while held
    pulseAndGrab("R2");
    step();
    rawIn = 1'b1;
    step();
    rawIn = 1'b0;
    step(); step();
    check("R6", lostFlag, 1'b1, "lost set by second edge");
    check("R6", heldOut, 1'b1, "held kept on loss");
    scanEnd = 1'b1;
    step();
    scanEnd = 1'b0;
    check("R6", heldOut, 1'b1, "end without read still ignored");
    readAndEnd();
    check("R6", heldOut, 1'b0, "single release after loss");
    check("R8", lostFlag, 1'b1, "lost sticky");
    step();
    check("R8", lostFlag, 1'b1, "lost sticky later");
    lostClr = 1'b1;
    step();
    lostClr = 1'b0;
    check("R8", lostFlag, 1'b0, "lost cleared");

    // R8: loss and clear in the same cycle
    pulseAndGrab("R2");
    step();
    lostClr = 1'b1;
    step();
    check("R8", lostFlag, 1'b0, "clear with nothing pending");
    rawIn = 1'b1;
    step();
    rawIn = 1'b0;
    step();
    step();
    lostClr = 1'b0;
    check("R8", lostFlag, 1'b1, "set wins over clear");
    readAndEnd();
    lostClr = 1'b1;
    step();
    lostClr = 1'b0;
    check("R8", lostFlag, 1'b0, "cleared again");

    // R7: release and new edge in the same cycle
    pulseAndGrab("R2");
    readPhase = 1'b1;
    step();
    readPhase = 1'b0;
    rawIn = 1'b1;
    step();
    rawIn = 1'b0;
    step();
    scanEnd = 1'b1;
    step();
    scanEnd = 1'b0;
    check("R7", heldOut, 1'b1, "recaptured at release");
    check("R7", lostFlag, 1'b0, "no loss at release");
    scanEnd = 1'b1;
    step();
    scanEnd = 1'b0;
    check("R7", heldOut, 1'b1, "read history cleared");
    readAndEnd();
    check("R7", heldOut, 1'b0, "second release");

    // R9: steady high input
    rawIn = 1'b1;
    step(); step(); step();
    check("R9", heldOut, 1'b1, "steady high grabbed");
    readAndEnd();
    for (int k = 0; k < 6; k++) step();
    check("R9", heldOut, 1'b0, "no recapture while high");
    check("R9", lostFlag, 1'b0, "no loss while high");
    rawIn = 1'b0;
    step();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule